// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets an on-chip requester read and write an external asynchronous static RAM of 128K words by 16 bits, with a separate enable for each byte lane. A request is accepted when `req_i` and `ready_o` are both high. The request carries an address, write data, a byte mask and a read/write select. Read data comes back on `rdata_o` with a single-cycle `rvalid_o` strobe.

On the memory side the block drives active-low select, output-enable and write-enable strobes and one active-low enable per byte lane. The bidirectional data bus is split into a driven value, a drive enable and a sampled input. Every memory timing limit is a parameter in nanoseconds. Each limit is turned into clock cycles by ceiling division by the clock period, so a nonzero limit costs at least one cycle and a zero limit costs none. Write cycles are controlled by the write strobe, and output enable stays high for the whole write. A write that directly follows a read gets one extra deselected cycle, so the memory has released the bus before the controller drives it.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `ready_o` is high, `rvalid_o` is low, the select, output-enable, write-enable and both lane enables are high, and `sram_dq_oe_o` is low.
- R2: A write holds the write strobe low for PW cycles. With ceiling division by the clock period, PW is the largest of the ceiled pulse width, the ceiled data setup time, and the ceiled address-to-end-of-write time minus the ceiled address setup. The write data is driven exactly while the strobe is low. Address and select stay steady for the whole access.
- R3: Mask bit 0 enables the lower lane (data bits 7..0) and mask bit 1 enables the upper lane (data bits 15..8). Each lane enable is low during the access only when its mask bit is 1. A lane with a 0 mask bit keeps its old content on a write, and a mask of 00 writes nothing.
- R4: A read holds select and output enable low and the write strobe high. The data bus is sampled on the clock edge that ends access cycle ACC, where ACC is the larger of the ceiled address-access and output-enable-access times. `rvalid_o` is high for the single cycle after that edge.
- R5: `ready_o` drops on the cycle after acceptance. It stays low for the larger of the ceiled cycle time and the active length of the access: ACC for a read, and setup + PW + recovery for a write. Requests presented while `ready_o` is low are ignored.
- R6: A write accepted directly after a read is preceded by exactly one cycle with select high, and this cycle adds one to its busy time. A write after a write, and a read after any access, start on the cycle after acceptance.
- R7: Output enable is high whenever the write strobe is low. The controller never drives the data bus while the memory may be driving it.
- R8: Whenever no access is in progress, select is high and the data bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| be_i | input | DW/8 | Byte mask, bit 0 = lower lane |
| ready_o | output | 1 | Controller can accept a request |
| rdata_o | output | DW | Read data |
| rvalid_o | output | 1 | Read data valid, one cycle |
| sram_addr_o | output | AW | Memory address |
| sram_ce_no | output | 1 | Memory select, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_lane_no | output | DW/8 | Lane enables, active low, bit 0 = lower |
| sram_dq_o | output | DW | Data driven onto the bus |
| sram_dq_oe_o | output | 1 | Bus drive enable |
| sram_dq_i | input | DW | Data sampled from the bus |

## Verification
The assertions check on every cycle the relations among the strobes. Output enable must be high under a write pulse, bus drive is allowed only inside a write pulse, the address must hold while select is low, lane enables may be active only when selected, and the valid pulse lasts one cycle. Properties over many cycles cannot be seen cycle by cycle. These are the exact pulse and busy lengths, the capture cycle, the lane masking, the extra cycle on a read-to-write change, and whether the memory meets its timing. They are shown by the bench's sweeps against a behavioural memory that flags short pulses, short setup, short cycle time and bus contention.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_RUN} ctl_state_e;

  function automatic int ns2cyc(input int t_ns, input int clk_ns);
    return (t_ns <= 0) ? 0 : (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_phase_cnt.sv
module sram_phase_cnt #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (clr_i)  cnt_o <= '0;
    else if (en_i)   cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |-> (cnt_o != '1)); // R5
endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode #(
  parameter int AW    = 17,
  parameter int DW    = 16,
  parameter int NLANE = 2,
  parameter int CW    = 2,
  parameter int C_AS  = 0,
  parameter int C_PW  = 2
) (
  input  logic             run_i,
  input  logic             wr_i,
  input  logic [CW-1:0]    cnt_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NLANE-1:0] be_i,
  output logic [AW-1:0]    addr_o,
  output logic             ce_no,
  output logic             oe_no,
  output logic             we_no,
  output logic [NLANE-1:0] lane_no,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  localparam logic [CW-1:0] WIN_HI = CW'(C_AS + C_PW);

  logic lo_ok, we_win;

  generate
    if (C_AS == 0) begin : g_no_setup
      assign lo_ok = 1'b1;
    end else begin : g_setup
      localparam logic [CW-1:0] WIN_LO = CW'(C_AS);
      assign lo_ok = (cnt_i >= WIN_LO);
    end
  endgenerate

  assign we_win = run_i && wr_i && lo_ok && (cnt_i < WIN_HI);

  generate
    for (genvar g = 0; g < NLANE; g++) begin : g_lane
      assign lane_no[g] = !(run_i && be_i[g]);
    end
  endgenerate

  assign addr_o  = addr_i;
  assign ce_no   = !run_i;
  assign oe_no   = !(run_i && !wr_i);
  assign we_no   = !we_win;
  assign dq_o    = wdata_i;
  assign dq_oe_o = we_win;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW     = 17,
  parameter int DW     = 16,
  parameter int CLK_NS = 4,
  parameter int T_WC   = 10,
  parameter int T_WP   = 7,
  parameter int T_AW   = 7,
  parameter int T_DW   = 5,
  parameter int T_AS   = 0,
  parameter int T_WR   = 0,
  parameter int T_RC   = 10,
  parameter int T_AA   = 10,
  parameter int T_OE   = 4,
  localparam int NLANE = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [NLANE-1:0] be_i,
  output logic             ready_o,
  output logic [DW-1:0]    rdata_o,
  output logic             rvalid_o,
  output logic [AW-1:0]    sram_addr_o,
  output logic             sram_ce_no,
  output logic             sram_oe_no,
  output logic             sram_we_no,
  output logic [NLANE-1:0] sram_lane_no,
  output logic [DW-1:0]    sram_dq_o,
  output logic             sram_dq_oe_o,
  input  logic [DW-1:0]    sram_dq_i
);
  import sram_ctrl_pkg::*;

  localparam int C_AS  = ns2cyc(T_AS, CLK_NS);
  localparam int C_WR  = ns2cyc(T_WR, CLK_NS);
  localparam int C_AW  = ns2cyc(T_AW, CLK_NS);
  localparam int C_PW  = imax(1, imax(imax(ns2cyc(T_WP, CLK_NS), ns2cyc(T_DW, CLK_NS)),
                                      C_AW - C_AS));
  localparam int N_W   = imax(ns2cyc(T_WC, CLK_NS), C_AS + C_PW + C_WR);
  localparam int C_ACC = imax(1, imax(ns2cyc(T_AA, CLK_NS), ns2cyc(T_OE, CLK_NS)));
  localparam int N_R   = imax(ns2cyc(T_RC, CLK_NS), C_ACC);
  localparam int N_MAX = imax(N_W, N_R);
  localparam int CW    = imax(1, $clog2(N_MAX + 1));
  localparam logic [CW-1:0] LAST_W = CW'(N_W - 1);
  localparam logic [CW-1:0] LAST_R = CW'(N_R - 1);
  localparam logic [CW-1:0] CAP_AT = CW'(C_ACC - 1);

  ctl_state_e       state_q;
  logic             op_wr_q, last_rd_q, rvalid_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q, rdata_q;
  logic [NLANE-1:0] be_q;
  logic [CW-1:0]    cnt;
  logic             run, last_beat, capture;

  assign run       = (state_q == ST_RUN);
  assign last_beat = run && (cnt == (op_wr_q ? LAST_W : LAST_R));
  assign capture   = run && !op_wr_q && (cnt == CAP_AT);

  sram_phase_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!run || last_beat),
    .en_i   (run),
    .cnt_o  (cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      op_wr_q   <= 1'b0;
      last_rd_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      rdata_q   <= '0;
      rvalid_q  <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= sram_dq_i;
      case (state_q)
        ST_IDLE: if (req_i) begin
          op_wr_q   <= wr_i;
          addr_q    <= addr_i;
          wdata_q   <= wdata_i;
          be_q      <= be_i;
          last_rd_q <= !wr_i;
          // bus turnaround: memory may still be driving after a read
          state_q   <= (wr_i && last_rd_q) ? ST_TURN : ST_RUN;
        end
        ST_TURN: state_q <= ST_RUN;
        ST_RUN:  if (last_beat) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o  = (state_q == ST_IDLE);
  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  sram_pin_decode #(
    .AW(AW), .DW(DW), .NLANE(NLANE), .CW(CW), .C_AS(C_AS), .C_PW(C_PW)
  ) u_pins (
    .run_i   (run),
    .wr_i    (op_wr_q),
    .cnt_i   (cnt),
    .addr_i  (addr_q),
    .wdata_i (wdata_q),
    .be_i    (be_q),
    .addr_o  (sram_addr_o),
    .ce_no   (sram_ce_no),
    .oe_no   (sram_oe_no),
    .we_no   (sram_we_no),
    .lane_no (sram_lane_no),
    .dq_o    (sram_dq_o),
    .dq_oe_o (sram_dq_oe_o)
  );

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no); // R7
  AST_DRIVE_IN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (!sram_we_no && !sram_ce_no)); // R2
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o)); // R2
  AST_LANE_NEEDS_CE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sram_lane_no) |-> !sram_ce_no); // R3
  AST_RVALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R4
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> !ready_o); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (sram_ce_no && !sram_dq_oe_o)); // R8
endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;
  localparam int AW = 17, DW = 16, CLK = 4;
  localparam int T_WC = 10, T_WP = 7, T_AW = 7, T_DW = 5, T_AS = 0, T_WR = 0;
  localparam int T_RC = 10, T_AA = 10, T_OE = 4;
  // expected cycle counts, ceiling division by the clock period
  localparam int E_AS  = (T_AS + CLK - 1) / CLK;
  localparam int E_WR  = (T_WR + CLK - 1) / CLK;
  localparam int E_WP0 = (T_WP + CLK - 1) / CLK;
  localparam int E_DW0 = (T_DW + CLK - 1) / CLK;
  localparam int E_AW0 = (T_AW + CLK - 1) / CLK - E_AS;
  localparam int E_PW1 = (E_WP0 > E_DW0) ? E_WP0 : E_DW0;
  localparam int E_PW  = (E_PW1 > E_AW0) ? E_PW1 : E_AW0;
  localparam int E_WC  = (T_WC + CLK - 1) / CLK;
  localparam int E_NW  = (E_WC > E_AS + E_PW + E_WR) ? E_WC : E_AS + E_PW + E_WR;
  localparam int E_AA  = (T_AA + CLK - 1) / CLK;
  localparam int E_OE  = (T_OE + CLK - 1) / CLK;
  localparam int E_ACC = (E_AA > E_OE) ? E_AA : E_OE;
  localparam int E_RC  = (T_RC + CLK - 1) / CLK;
  localparam int E_NR  = (E_RC > E_ACC) ? E_RC : E_ACC;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [1:0] be_i = '0;
  logic ready_o, rvalid_o, sram_ce_no, sram_oe_no, sram_we_no, sram_dq_oe_o;
  logic [DW-1:0] rdata_o, sram_dq_o, sram_dq_i;
  logic [AW-1:0] sram_addr_o;
  logic [1:0] sram_lane_no;

  int checks = 0, errors = 0;

  always #(CLK/2) clk = ~clk;

  sram_ctrl #(.AW(AW), .DW(DW), .CLK_NS(CLK), .T_WC(T_WC), .T_WP(T_WP), .T_AW(T_AW),
    .T_DW(T_DW), .T_AS(T_AS), .T_WR(T_WR), .T_RC(T_RC), .T_AA(T_AA), .T_OE(T_OE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .be_i(be_i), .ready_o(ready_o), .rdata_o(rdata_o),
    .rvalid_o(rvalid_o), .sram_addr_o(sram_addr_o), .sram_ce_no(sram_ce_no),
    .sram_oe_no(sram_oe_no), .sram_we_no(sram_we_no), .sram_lane_no(sram_lane_no),
    .sram_dq_o(sram_dq_o), .sram_dq_oe_o(sram_dq_oe_o), .sram_dq_i(sram_dq_i));

  // ---------------- behavioural memory ----------------
  logic [15:0] mem_a [int];
  logic [15:0] exp_a [int];
  int viol_t = 0, viol_c = 0;
  int cyc = 0, we_run = 0, ds_run = 0, last_fall = -1000, rd_run = 0;
  logic [AW-1:0] w_addr, rd_addr;
  logic [15:0] w_data, prev_dq, mem_val;
  logic [1:0] w_lane, mem_drv;
  logic prev_oe = 1'b0;

  function automatic logic [15:0] init_word(input int a);
    return 16'(a) ^ 16'hA5C3;
  endfunction

  function automatic logic [15:0] mem_rd(input int a);
    return mem_a.exists(a) ? mem_a[a] : init_word(a);
  endfunction

  function automatic logic [15:0] exp_rd(input int a);
    return exp_a.exists(a) ? exp_a[a] : init_word(a);
  endfunction

  always_comb begin
    sram_dq_i[7:0]  = mem_drv[0] ? mem_val[7:0]  : 8'h00;
    sram_dq_i[15:8] = mem_drv[1] ? mem_val[15:8] : 8'h00;
  end

  initial begin mem_drv = 2'b00; mem_val = '0; end

  always @(negedge clk) begin
    logic [15:0] cur;
    cyc++;
    if (!sram_ce_no && !sram_we_no) begin
      if (we_run == 0) begin
        if ((cyc - last_fall) * CLK < T_WC) viol_t++;
        last_fall = cyc;
      end else if (sram_addr_o != w_addr) viol_t++;
      we_run++;
      if (sram_dq_oe_o && prev_oe && sram_dq_o == prev_dq) ds_run++;
      else ds_run = sram_dq_oe_o ? 1 : 0;
      w_addr = sram_addr_o; w_data = sram_dq_o; w_lane = sram_lane_no;
    end else if (we_run > 0) begin
      if (we_run * CLK < T_WP) viol_t++;
      if (ds_run * CLK < T_DW) viol_t++;
      cur = mem_rd(int'(w_addr));
      if (!w_lane[0]) cur[7:0]  = w_data[7:0];
      if (!w_lane[1]) cur[15:8] = w_data[15:8];
      mem_a[int'(w_addr)] = cur;
      we_run = 0;
    end
    prev_dq = sram_dq_o; prev_oe = sram_dq_oe_o;
    if (!sram_ce_no && !sram_oe_no && sram_we_no) begin
      if (rd_run > 0 && sram_addr_o == rd_addr) rd_run++;
      else rd_run = 1;
      rd_addr = sram_addr_o;
      mem_drv = ~sram_lane_no;
      mem_val = (rd_run * CLK >= T_AA && rd_run * CLK >= T_OE)
                ? mem_rd(int'(sram_addr_o)) : 16'hDEAD;
    end else begin
      rd_run = 0; mem_drv = 2'b00;
    end
    if (sram_dq_oe_o && (mem_drv != 2'b00)) viol_c++;
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  bit prev_read = 1'b0;

  task automatic wait_ready();
    int guard = 0;
    while (!ready_o && guard < 100) begin @(negedge clk); guard++; end
  endtask

  task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] be,
                          input bit poke, input int poke_a);
    int busy = 0, turn_c = 0, we_c = 0, bad_lane = 0, bad_drv = 0, bad_oe = 0;
    logic [15:0] cur;
    wait_ready();
    req_i = 1'b1; wr_i = 1'b1; addr_i = AW'(a); wdata_i = d; be_i = be;
    @(negedge clk);
    while (!ready_o && busy < 100) begin
      if (busy == 0 && poke) begin
        req_i = 1'b1; wr_i = 1'b1; addr_i = AW'(poke_a); wdata_i = 16'h5A5A; be_i = 2'b11;
      end else req_i = 1'b0;
      busy++;
      if (sram_ce_no) turn_c++;
      if (!sram_we_no) begin
        we_c++;
        if (sram_lane_no != ~be) bad_lane++;
        if (!sram_dq_oe_o || sram_dq_o != d) bad_drv++;
        if (!sram_oe_no) bad_oe++;
      end else if (sram_dq_oe_o) bad_drv++;
      @(negedge clk);
    end
    req_i = 1'b0;
    chk("R2 pulse cycles", we_c, E_PW);
    chk("R2 data driven only in pulse", bad_drv, 0);
    chk("R3 lane enables", bad_lane, 0);
    chk("R7 oe high in write", bad_oe, 0);
    chk("R6 turnaround cycles", turn_c, prev_read ? 1 : 0);
    chk("R5 write busy cycles", busy, E_NW + (prev_read ? 1 : 0));
    cur = exp_rd(a);
    if (be[0]) cur[7:0]  = d[7:0];
    if (be[1]) cur[15:8] = d[15:8];
    exp_a[a] = cur;
    prev_read = 1'b0;
  endtask

  task automatic do_read(input int a, input logic [1:0] be);
    int busy = 0, turn_c = 0, bad = 0, rv_cnt = 0, rv_idx = -1;
    logic [15:0] m;
    wait_ready();
    req_i = 1'b1; wr_i = 1'b0; addr_i = AW'(a); be_i = be;
    @(negedge clk);
    req_i = 1'b0;
    while (!ready_o && busy < 100) begin
      if (rvalid_o) begin rv_cnt++; rv_idx = busy; end
      if (sram_ce_no) turn_c++;
      else if (sram_oe_no || !sram_we_no || sram_dq_oe_o || sram_lane_no != ~be) bad++;
      busy++;
      @(negedge clk);
    end
    if (rvalid_o) begin rv_cnt++; rv_idx = busy; end
    m = {{8{be[1]}}, {8{be[0]}}};
    chk("R4 read strobes", bad, 0);
    chk("R4 capture latency", rv_idx, E_ACC);
    chk("R4 valid pulses", rv_cnt, 1);
    chk("R3 read data lanes", rdata_o & m, exp_rd(a) & m);
    chk("R6 no turnaround before read", turn_c, 0);
    chk("R5 read busy cycles", busy, E_NR);
    prev_read = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 idle pins", {ready_o, rvalid_o, sram_ce_no, sram_oe_no, sram_we_no,
                         sram_lane_no, sram_dq_oe_o}, 8'b1011_1110);
    // R8 nothing selected before first request
    chk("R8 deselected idle", {sram_ce_no, sram_dq_oe_o}, 2'b10);

    for (int i = 0; i < 14; i++) begin
      int a;
      a = (i == 13) ? 32'h1FFFF : (i * 10007) % 131072;
      do_read(a, 2'b11);
      for (int b = 0; b < 4; b++) begin
        do_write(a, 16'((a * 37) + b * 4099 + i), 2'(b), 1'b0, 0);
        do_read(a, 2'(b));
        do_read(a, 2'b11);
      end
      do_write(a, 16'hC0DE ^ 16'(i), 2'b11, 1'b0, 0);
      do_write(a ^ 1, 16'h0BAD ^ 16'(i), 2'b01, 1'b0, 0);
      do_read(a, 2'b11);
      do_read(a ^ 1, 2'b11);
    end

    // R5 request presented while busy is ignored
    do_write(100, 16'h1234, 2'b11, 1'b1, 200);
    do_read(200, 2'b11);
    do_read(100, 2'b11);

    wait_ready();
    repeat (2) @(negedge clk);
    chk("R8 idle after traffic", {sram_ce_no, sram_dq_oe_o}, 2'b10);
    chk("R2 memory timing violations", viol_t, 0);
    chk("R7 bus contention events", viol_c, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule